// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target-side protocol engine of a small byte-addressed memory reached over a two-wire serial bus. It runs from a fast system clock and oversamples the bus clock and data lines. It recognises bus start and stop conditions and shifts incoming words in MSB first. A select byte is matched against a fixed four-bit prefix and three strap inputs. On a match the engine answers on the data line with an open-drain pull-low enable.

Once selected, the engine runs the write sequences: a single byte, or several bytes in one page. It also runs the read sequences: from the current address, from an address set by a dummy write followed by a repeated start, and sequential reads that continue while the host acknowledges. The storage array sits outside the block. It is reached through an address bus, a one-cycle write strobe with write data, and a one-cycle read strobe with combinational read data. The address counter lives inside the engine.

Top module: `twm_target`

## Requirements
- R1: After reset the SDA pull enable and both memory strobes are low. A start condition (SDA falling while SCL is high) at any point abandons the current transfer and begins a new select byte; the word address already loaded is kept. A stop condition (SDA rising while SCL is high) returns the engine to idle with SDA released.
- R2: The first byte after a start is the select byte. Bits 7..4 must be 1010 and bits 3..1 must equal `strap_i[2:0]`. On a match the engine pulls SDA low for the ninth clock. Bit 0 selects read (1) or write (0).
- R3: On a select mismatch the engine gives no acknowledge and leaves SDA released for the rest of the transfer, until the next start.
- R4: In a write transfer, the byte after the select byte is loaded into the address counter and acknowledged.
- R5: Each later byte of a write transfer is acknowledged. It is stored through exactly one `mem_we_o` pulse at the current address, and the address then advances.
- R6: During writes only the low PAGE_W address bits advance, wrapping inside the page; the upper bits stay fixed. A ninth byte into an 8-byte page overwrites the first byte of the transfer.
- R7: A read transfer begun directly after a start returns the byte at the current address. The current address is the one after the last byte accessed.
- R8: A write-mode select byte plus a word address, followed by a repeated start and a read-mode select byte, returns the byte at that word address.
- R9: In a read, a host acknowledge (SDA low on the ninth clock) makes the engine send the next byte. The address wraps from the top of the array to zero.
- R10: After the host does not acknowledge a read byte, the engine leaves SDA released until a stop or a start, whatever clocks follow.
- R11: The engine samples input data on SCL rising edges. It changes its SDA pull enable only while SCL is low, after a falling edge.
- R12: With STRAP_EN = 0 the strap inputs are ignored and select bits 3..1 must be 000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line, as seen on the wire |
| strap_i | input | 3 | Hard-wired select bits compared with select bits 3..1 |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_addr_o | output | AW | Address counter value presented to the array |
| mem_wdata_o | output | 8 | Byte to store, valid with mem_we_o |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_rd_o | output | 1 | One-cycle strobe marking the cycle a read byte is taken |
| mem_rdata_i | input | 8 | Combinational array data at mem_addr_o |

## Verification
Each bus edge reaches the state register three to four system clocks after the raw line moves: two synchroniser stages, one edge-detect stage and the state flop. So the acknowledge or data bit appears about four cycles after the SCL falling edge that starts it. The write strobe follows four cycles after the eighth rising edge. The bench holds every SCL phase for eight system clocks and samples SDA in the middle of the high phase, well after the engine has settled and well before the next edge. A scoreboard queue holds the expected acknowledge and data values in bus order. Array contents are checked after each stop, and a background process flags any change of the pull enable while SCL is high.

// File: rtl/twm_pkg.sv
`timescale 1ns/1ps
package twm_pkg;

    // Engine phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK_OUT,
        ST_TX,
        ST_ACK_IN,
        ST_WAIT_STOP
    } tgt_state_e;

    // Meaning of the byte being received
    typedef enum logic [1:0] {
        BK_SEL,
        BK_WADDR,
        BK_WDATA
    } byte_kind_e;

    localparam logic [3:0] SEL_PREFIX = 4'b1010;

    typedef struct packed {
        tgt_state_e st;
        byte_kind_e kind;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       rd_mode;
        logic       oe;
        logic       we;
        logic       rd;
        logic       host_ack;
    } tgt_regs_t;

endpackage

// File: rtl/twm_line_sync.sv
`timescale 1ns/1ps
module twm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_pipe_d, scl_pipe_q;
    logic [PW-1:0] sda_pipe_d, sda_pipe_q;
    logic scl_cur, scl_prv, sda_cur, sda_prv;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[PW-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
        end
    end

    assign scl_cur = scl_pipe_q[STAGES-1];
    assign scl_prv = scl_pipe_q[STAGES];
    assign sda_cur = sda_pipe_q[STAGES-1];
    assign sda_prv = sda_pipe_q[STAGES];

    assign sda_s     = sda_cur;
    assign scl_rise  = scl_cur & ~scl_prv;
    assign scl_fall  = ~scl_cur & scl_prv;
    assign start_det = scl_cur & scl_prv & sda_prv & ~sda_cur;
    assign stop_det  = scl_cur & scl_prv & ~sda_prv & sda_cur;

endmodule

// File: rtl/twm_addr_ctr.sv
`timescale 1ns/1ps
module twm_addr_ctr #(
    parameter int AW = 8,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] ld_val,
    input  logic          inc_page,
    input  logic          inc_full,
    output logic [AW-1:0] addr
);
    localparam int HW = AW - PW;

    logic [AW-1:0] addr_d, addr_q;
    logic [PW-1:0] low_next;

    always_comb begin
        low_next = addr_q[PW-1:0] + {{(PW-1){1'b0}}, 1'b1};
        addr_d   = addr_q;
        if (ld) begin
            addr_d = ld_val;
        end else if (inc_page) begin
            addr_d = {addr_q[AW-1:PW], low_next};
        end else if (inc_full) begin
            addr_d = addr_q + {{(AW-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    // Write stepping must keep the page row
    p_page_row_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_page && !ld) |=> (addr_q[AW-1:PW] == $past(addr_q[AW-1:PW])))
        else $error("page row changed on write step");

    // Read stepping covers the whole array and wraps at the top
    p_read_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_full && !ld && !inc_page) |=> (addr_q == $past(addr_q) + {{(AW-1){1'b0}}, 1'b1}))
        else $error("read step wrong");

    logic [HW-1:0] unused_hw;
    assign unused_hw = '0;

endmodule

// File: rtl/twm_target.sv
`timescale 1ns/1ps
module twm_target
    import twm_pkg::*;
#(
    parameter int AW          = 8,
    parameter int PAGE_W      = 3,
    parameter int STRAP_EN    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [2:0]    strap_i,
    output logic          sda_oe_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [7:0]    mem_wdata_o,
    output logic          mem_we_o,
    output logic          mem_rd_o,
    input  logic [7:0]    mem_rdata_i
);
    localparam logic [2:0] BIT_LAST = 3'd7;

    tgt_regs_t     r_d, r_q;
    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [2:0]    strap_eff;
    logic [7:0]    byte_in;
    logic          ctr_ld;
    logic [AW-1:0] ctr_ld_val;

    twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twm_addr_ctr #(.AW(AW), .PW(PAGE_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (ctr_ld),
        .ld_val   (ctr_ld_val),
        .inc_page (r_q.we),
        .inc_full (r_q.rd),
        .addr     (mem_addr_o)
    );

    generate
        if (STRAP_EN != 0) begin : g_strap
            assign strap_eff = strap_i;
        end else begin : g_nostrap
            logic [2:0] strap_unused;
            assign strap_unused = strap_i;
            assign strap_eff    = 3'b000;
        end
    endgenerate

    assign byte_in = {r_q.sh[6:0], sda_s};

    always_comb begin
        r_d        = r_q;
        r_d.we     = 1'b0;
        r_d.rd     = 1'b0;
        ctr_ld     = 1'b0;
        ctr_ld_val = byte_in[AW-1:0];

        case (r_q.st)
            ST_RX: begin
                if (scl_rise) begin
                    r_d.sh  = byte_in;
                    r_d.cnt = r_q.cnt + 3'd1;
                    if (r_q.cnt == BIT_LAST) begin
                        r_d.cnt = 3'd0;
                        r_d.st  = ST_ACK_SETUP;
                        case (r_q.kind)
                            BK_SEL: begin
                                if (byte_in[7:4] == SEL_PREFIX && byte_in[3:1] == strap_eff) begin
                                    r_d.rd_mode = byte_in[0];
                                    r_d.kind    = BK_WADDR;
                                end else begin
                                    r_d.st = ST_IDLE;
                                end
                            end
                            BK_WADDR: begin
                                ctr_ld   = 1'b1;
                                r_d.kind = BK_WDATA;
                            end
                            default: begin
                                r_d.we = 1'b1;
                            end
                        endcase
                    end
                end
            end
            ST_ACK_SETUP: begin
                if (scl_fall) begin
                    r_d.oe = 1'b1;
                    r_d.st = ST_ACK_OUT;
                end
            end
            ST_ACK_OUT: begin
                if (scl_fall) begin
                    r_d.cnt = 3'd0;
                    if (r_q.rd_mode) begin
                        r_d.sh = mem_rdata_i;
                        r_d.rd = 1'b1;
                        r_d.oe = ~mem_rdata_i[7];
                        r_d.st = ST_TX;
                    end else begin
                        r_d.oe = 1'b0;
                        r_d.st = ST_RX;
                    end
                end
            end
            ST_TX: begin
                if (scl_fall) begin
                    if (r_q.cnt == BIT_LAST) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = 3'd0;
                        r_d.st  = ST_ACK_IN;
                    end else begin
                        r_d.sh  = {r_q.sh[6:0], 1'b0};
                        r_d.oe  = ~r_q.sh[6];
                        r_d.cnt = r_q.cnt + 3'd1;
                    end
                end
            end
            ST_ACK_IN: begin
                if (scl_rise) begin
                    r_d.host_ack = ~sda_s;
                end
                if (scl_fall) begin
                    if (r_q.host_ack) begin
                        r_d.sh  = mem_rdata_i;
                        r_d.rd  = 1'b1;
                        r_d.oe  = ~mem_rdata_i[7];
                        r_d.cnt = 3'd0;
                        r_d.st  = ST_TX;
                    end else begin
                        r_d.st = ST_WAIT_STOP;
                    end
                end
            end
            default: begin
            end
        endcase

        if (stop_det) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end
        if (start_det) begin
            r_d.st   = ST_RX;
            r_d.kind = BK_SEL;
            r_d.cnt  = 3'd0;
            r_d.oe   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_oe_o    = r_q.oe;
    assign mem_we_o    = r_q.we;
    assign mem_rd_o    = r_q.rd;
    assign mem_wdata_o = r_q.sh;

    // A stop always leaves the bus released and the engine idle
    p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe_o && r_q.st == ST_IDLE))
        else $error("stop did not release");

    // A start always restarts select reception
    p_start_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (r_q.st == ST_RX && r_q.kind == BK_SEL && r_q.cnt == 3'd0))
        else $error("start did not restart");

    // Idle never drives the line (covers the mismatch path)
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !sda_oe_o)
        else $error("driving while idle");

    // After a host not-acknowledge the line stays released
    p_nack_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT_STOP) |-> !sda_oe_o)
        else $error("driving after host nack");

    // Pull-low begins only right after a bus clock falling edge
    p_pull_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> $past(scl_fall))
        else $error("pull-low outside clock low phase");

    // Write and read strobes never coincide
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we_o, mem_rd_o}))
        else $error("write and read strobes together");

endmodule

// File: tb/sim_twm_target.sv
`timescale 1ns/1ps
module sim_twm_target;
    localparam int AW = 8;
    localparam int Q  = 8;

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic scl_h = 1'b1;
    logic sda_h = 1'b1;
    logic oe0, oe1;
    wire  sda_bus0 = sda_h & ~oe0;
    wire  sda_bus1 = sda_h & ~oe1;

    logic [AW-1:0] addr0, addr1;
    logic [7:0]    wdata0, wdata1, rdata0;
    logic          we0, rd0, we1, rd1;
    logic [7:0]    mem [256];

    twm_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus0), .strap_i(3'b011),
        .sda_oe_o(oe0), .mem_addr_o(addr0), .mem_wdata_o(wdata0), .mem_we_o(we0),
        .mem_rd_o(rd0), .mem_rdata_i(rdata0)
    );

    twm_target #(.STRAP_EN(0)) u1 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_h), .sda_i(sda_bus1), .strap_i(3'b101),
        .sda_oe_o(oe1), .mem_addr_o(addr1), .mem_wdata_o(wdata1), .mem_we_o(we1),
        .mem_rd_o(rd1), .mem_rdata_i(8'h00)
    );

    always @(posedge clk) if (we0) mem[addr0] <= wdata0;
    assign rdata0 = mem[addr0];

    int checks = 0;
    int errors = 0;
    int r11_viol = 0;
    logic oe0_prev = 1'b0;

    // R11 watcher: pull enable must not move while the clock line is high
    always @(negedge clk) begin
        if (rst_n && (oe0 != oe0_prev) && scl_h) r11_viol++;
        oe0_prev = oe0;
    end

    typedef struct { string tag; logic [7:0] val; } exp_t;
    exp_t exp_q[$];

    task automatic push_exp(input string tag, input logic [7:0] v);
        exp_t e;
        e.tag = tag;
        e.val = v;
        exp_q.push_back(e);
    endtask

    // Monitor side of the scoreboard: pops the oldest expectation per result
    task automatic monitor_cmp(input logic [7:0] got);
        exp_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard empty: actual %h expected none", got);
        end else begin
            e = exp_q.pop_front();
            if (got !== e.val) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", e.tag, got, e.val);
            end
        end
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] want);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, got, want);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_h = 1'b1; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_h = 1'b0; tick(Q);
        scl_h = 1'b1; tick(Q);
        sda_h = 1'b1; tick(Q);
    endtask

    task automatic bus_bit(input logic b, output logic s0, output logic s1);
        sda_h = b;    tick(Q);
        scl_h = 1'b1; tick(Q/2);
        s0 = sda_bus0;
        s1 = sda_bus1;
        tick(Q/2);
        scl_h = 1'b0; tick(Q/2);
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack0, output logic ack1);
        logic s0, s1;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s0, s1);
        bus_bit(1'b1, ack0, ack1);
    endtask

    task automatic read_byte(input logic host_ack, output logic [7:0] v);
        logic s0, s1;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s0, s1);
            v[i] = s0;
        end
        bus_bit(~host_ack, s0, s1);
    endtask

    task automatic send_acked(input string tag, input logic [7:0] v);
        logic a0, a1;
        push_exp(tag, 8'h00);
        write_byte(v, a0, a1);
        monitor_cmp({7'd0, a0});
    endtask

    task automatic read_expect(input string tag, input logic host_ack, input logic [7:0] want);
        logic [7:0] v;
        push_exp(tag, want);
        read_byte(host_ack, v);
        monitor_cmp(v);
    endtask

    initial begin : main
        logic a0, a1;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hC3;
        tick(5);
        // R1: reset state
        check("R1 reset pull", {7'd0, oe0}, 8'h00);
        check("R1 reset strobe", {6'd0, we0, rd0}, 8'h00);
        rst_n = 1'b1;
        tick(5);

        // R2 R4 R5: byte write of 5A at 10
        bus_start;
        send_acked("R2 select ack", 8'hA6);
        send_acked("R4 word address ack", 8'h10);
        send_acked("R5 data ack", 8'h5A);
        bus_stop;
        tick(4);
        check("R5 stored byte", mem[8'h10], 8'h5A);

        // R8: dummy write then repeated start
        bus_start;
        send_acked("R8 select ack", 8'hA6);
        send_acked("R8 address ack", 8'h10);
        bus_start;
        send_acked("R8 read select ack", 8'hA7);
        read_expect("R8 random read", 1'b0, 8'h5A);
        bus_stop;

        // R7: current address is 11
        bus_start;
        send_acked("R7 select ack", 8'hA7);
        read_expect("R7 current read", 1'b0, 8'hD2);
        bus_stop;

        // R6: nine bytes from 1E roll over inside page 18..1F
        bus_start;
        send_acked("R6 select ack", 8'hA6);
        send_acked("R6 address ack", 8'h1E);
        for (int k = 0; k < 9; k++) send_acked("R6 page data ack", 8'hB0 + 8'(k));
        bus_stop;
        tick(4);
        check("R6 rewritten first", mem[8'h1E], 8'hB8);
        check("R6 page end", mem[8'h1F], 8'hB1);
        check("R6 wrap to page start", mem[8'h18], 8'hB2);
        check("R6 last in page", mem[8'h1D], 8'hB7);
        check("R6 next page untouched", mem[8'h20], 8'hE3);

        // R9: sequential read across the top of the array
        bus_start;
        send_acked("R9 select ack", 8'hA6);
        send_acked("R9 address ack", 8'hFE);
        bus_start;
        send_acked("R9 read select ack", 8'hA7);
        read_expect("R9 seq byte FE", 1'b1, 8'h3D);
        read_expect("R9 seq byte FF", 1'b1, 8'h3C);
        read_expect("R9 seq wrap 00", 1'b1, 8'hC3);
        read_expect("R9 seq byte 01", 1'b0, 8'hC2);
        // R10: clocks after the nack see a released line
        read_expect("R10 released after nack", 1'b0, 8'hFF);
        bus_stop;

        // R3 R12: strap bits 000 miss u0 but hit u1 (straps ignored)
        bus_start;
        push_exp("R3 no ack on mismatch", 8'h01);
        push_exp("R12 strapless ack", 8'h00);
        write_byte(8'hA0, a0, a1);
        monitor_cmp({7'd0, a0});
        monitor_cmp({7'd0, a1});
        read_expect("R3 released after mismatch", 1'b0, 8'hFF);
        bus_stop;

        // R2: wrong prefix
        bus_start;
        push_exp("R2 wrong prefix nack", 8'h01);
        write_byte(8'hB6, a0, a1);
        monitor_cmp({7'd0, a0});
        bus_stop;

        // R1: start in the middle of a data byte aborts it
        bus_start;
        send_acked("R1 select ack", 8'hA6);
        send_acked("R1 address ack", 8'h40);
        for (int k = 0; k < 4; k++) bus_bit(1'b0, a0, a1);
        bus_start;
        send_acked("R1 read select after abort", 8'hA7);
        read_expect("R1 address kept", 1'b0, 8'h83);
        bus_stop;
        tick(4);
        check("R1 aborted byte not stored", mem[8'h40], 8'h83);

        check("R11 pull changes during clock high", 8'(r11_viol), 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule